// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one character into one asynchronous serial frame on a single line that rests high. A client offers a data word with a one-cycle load strobe. The strobe takes effect only while the ready output is high. The frame layout is set at run time by three encoded inputs: a character-size code (5 to 9 data bits), a parity mode (none, even or odd) and a stop-bit select (one or two). The layout and the data are latched when the character is accepted. An external generator supplies a one-cycle bit-rate tick, and each frame bit lasts sixteen of those ticks.

Control lives in one state machine with six states. `IDLE` drives the line high and raises ready. On an accepted load (`IDLE->START`) the frame begins. `START` drives the line low. After sixteen ticks the machine moves to `DATA` (`START->DATA`), which sends the active data bits LSB first. After the last data bit it goes to `PARITY` when parity is enabled (`DATA->PARITY`) and to `STOP1` when it is not (`DATA->STOP1`). `PARITY` always continues to `STOP1` (`PARITY->STOP1`). `STOP1` returns to `IDLE` for one stop bit (`STOP1->IDLE`) or moves to `STOP2` for two (`STOP1->STOP2`). `STOP2` returns to `IDLE` (`STOP2->IDLE`). No state changes except on a tick that completes a bit, apart from `IDLE->START`, which follows the load strobe.

Top module: `async_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, txd is 1 and ready is 1.
- R2: A load strobe seen while ready is 1 starts a frame at the next clock edge. ready then stays 0 until the clock edge that ends the last stop bit, and is 1 from that edge on.
- R3: The first bit of each frame is a start bit with txd = 0.
- R4: The data bits follow the start bit, LSB first. size_code 000, 001, 010 and 011 give 5, 6, 7 and 8 bits. 111 gives 9 bits. The reserved codes 100, 101 and 110 give 8 bits. Data bits above the selected size are not sent.
- R5: par_mode 00 and the reserved code 01 send no parity bit. 10 sends one even-parity bit and 11 sends one odd-parity bit, right after the last data bit.
- R6: The parity bit is the XOR of the sent data bits only. It is inverted for odd parity.
- R7: After the data bits (and parity bit, if any) come stop bits with txd = 1. There is one when two_stop = 0 and two when two_stop = 1.
- R8: Every frame bit lasts exactly 16 tick pulses. Clock cycles without a tick never advance the frame.
- R9: size_code, par_mode and two_stop are sampled only when a load is accepted. Changing them during a frame leaves that frame unchanged.
- R10: A load strobe while ready is 0 is ignored. Neither the data nor the layout of the frame in progress changes, and no extra frame follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle bit-rate pulse, 16 per frame bit |
| load | input | 1 | Request to send `data` |
| ready | output | 1 | High when a load will be accepted |
| data | input | DATA_W | Character; bit 0 is sent first |
| size_code | input | 3 | Character-size code |
| par_mode | input | 2 | Parity-mode code |
| two_stop | input | 1 | 0: one stop bit, 1: two stop bits |
| txd | output | 1 | Serial output, high at rest |

## Verification
The hardest case to reach from the ports is a frame that is disturbed while in flight, so that it must survive both input changes and a second request. In every frame of the sweep, at a fixed tick count inside the data field, the bench pulses load with the inverted word and flips every layout code. It then checks that each later bit still matches the frame computed at acceptance and that no second frame follows. Tick pulses come every third cycle, with a recurring gap of several cycles, and the line is compared against the expected bit on every cycle. A bit that ends early, ends late or moves without a tick therefore shows up.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;

    localparam int SIZE_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP1  = 3'd4,
        ST_STOP2  = 3'd5
    } tx_state_t;

    typedef struct packed {
        logic [SIZE_W-1:0] nbits;
        logic              par_en;
        logic              par_odd;
        logic              two_stop;
    } frame_cfg_t;

endpackage

// File: rtl/frame_cfg_decode.sv
module frame_cfg_decode
    import frame_tx_pkg::*;
(
    input  logic [2:0]  size_code,
    input  logic [1:0]  par_mode,
    input  logic        two_stop,
    output frame_cfg_t  cfg
);

    always_comb begin
        cfg = '0;
        unique case (size_code)
            3'b000:  cfg.nbits = SIZE_W'(5);
            3'b001:  cfg.nbits = SIZE_W'(6);
            3'b010:  cfg.nbits = SIZE_W'(7);
            3'b111:  cfg.nbits = SIZE_W'(9);
            default: cfg.nbits = SIZE_W'(8);   // 011 and reserved 100..110
        endcase
        cfg.par_en   = par_mode[1];            // 01 reserved -> no parity
        cfg.par_odd  = par_mode[1] & par_mode[0];
        cfg.two_stop = two_stop;
    end

    always_comb begin
        if (!(cfg.nbits >= SIZE_W'(5) && cfg.nbits <= SIZE_W'(9)))
            assert (0) else $error("AST_SIZE_RANGE");   // R4
    end

endmodule

// File: rtl/baud_phase_counter.sv
module baud_phase_counter #(
    parameter int OVERSAMPLE = 16,
    localparam int PH_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic bit_end
);

    logic [PH_W-1:0] phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase <= '0;
        else if (clr)
            phase <= '0;
        else if (tick)
            phase <= (phase == PH_W'(OVERSAMPLE-1)) ? '0 : phase + 1'b1;
    end

    assign bit_end = tick && (phase == PH_W'(OVERSAMPLE-1));

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(phase)) else $error("AST_PHASE_HOLD");   // R8

endmodule

// File: rtl/async_frame_tx.sv
module async_frame_tx
    import frame_tx_pkg::*;
#(
    parameter int DATA_W     = 9,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    output logic              ready,
    input  logic [DATA_W-1:0] data,
    input  logic [2:0]        size_code,
    input  logic [1:0]        par_mode,
    input  logic              two_stop,
    output logic              txd
);

    localparam int IDX_W = SIZE_W;

    tx_state_t         state, state_nx;
    frame_cfg_t        cfg_in, cfg_q;
    logic [DATA_W-1:0] data_mask, data_q;
    logic              par_q;
    logic [IDX_W-1:0]  bit_idx;
    logic              bit_end, accept, last_data;

    frame_cfg_decode u_dec (
        .size_code (size_code),
        .par_mode  (par_mode),
        .two_stop  (two_stop),
        .cfg       (cfg_in)
    );

    baud_phase_counter #(.OVERSAMPLE(OVERSAMPLE)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .tick    (tick),
        .bit_end (bit_end)
    );

    assign accept = load && (state == ST_IDLE);

    // keep only the active character bits
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign data_mask[i] = data[i] & (IDX_W'(i) < cfg_in.nbits);
    end

    assign last_data = (bit_idx == cfg_q.nbits - 1'b1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (load)    state_nx = ST_START;
            ST_START:  if (bit_end) state_nx = ST_DATA;
            ST_DATA:   if (bit_end && last_data)
                           state_nx = cfg_q.par_en ? ST_PARITY : ST_STOP1;
            ST_PARITY: if (bit_end) state_nx = ST_STOP1;
            ST_STOP1:  if (bit_end) state_nx = cfg_q.two_stop ? ST_STOP2 : ST_IDLE;
            ST_STOP2:  if (bit_end) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // frame capture and bit index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            data_q  <= '0;
            par_q   <= 1'b0;
            bit_idx <= '0;
        end else if (accept) begin
            cfg_q   <= cfg_in;
            data_q  <= data_mask;
            par_q   <= (^data_mask) ^ cfg_in.par_odd;
            bit_idx <= '0;
        end else if (state == ST_DATA && bit_end && !last_data) begin
            bit_idx <= bit_idx + 1'b1;
        end
    end

    // outputs
    always_comb begin
        ready = 1'b0;
        txd   = 1'b1;
        unique case (state)
            ST_IDLE:   ready = 1'b1;
            ST_START:  txd   = 1'b0;
            ST_DATA:   txd   = data_q[bit_idx];
            ST_PARITY: txd   = par_q;
            ST_STOP1,
            ST_STOP2:  txd   = 1'b1;
            default:   txd   = 1'b1;
        endcase
    end

    AST_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && load) |=> (!txd && !ready)) else $error("AST_ACCEPT_START");   // R3

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !tick) |=> $stable(state)) else $error("AST_NO_TICK_HOLD");   // R8

    AST_BUSY_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && load) |=> ($stable(data_q) && $stable(par_q))) else $error("AST_BUSY_DATA_HELD");   // R10

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(cfg_q)) else $error("AST_CFG_HELD");   // R9

    AST_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> txd) else $error("AST_IDLE_LINE");   // R1

endmodule

// File: tb/sim_async_frame_tx.sv
`timescale 1ns/1ps
module sim_async_frame_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       load = 1'b0;
    logic       ready, txd;
    logic [8:0] data = '0;
    logic [2:0] size_code = '0;
    logic [1:0] par_mode = '0;
    logic       two_stop = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int tick_cnt = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    async_frame_tx u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .ready(ready),
        .data(data), .size_code(size_code), .par_mode(par_mode),
        .two_stop(two_stop), .txd(txd)
    );

    // tick every third cycle, with a recurring idle gap
    always @(negedge clk) begin
        tick_cnt <= tick_cnt + 1;
        tick     <= ((tick_cnt % 3) == 0) && ((tick_cnt % 97) < 80);
    end

    task automatic chk(input string req, input logic act, input logic exp, input int info);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b (case %0d)", req, act, exp, info);
        end
    endtask

    task automatic send(input logic [8:0] d, input logic [2:0] sc, input logic [1:0] pm, input logic ts, input int id);
        logic [12:0] fr;
        string       rq [13];
        int nb, total, k, pos;
        logic p;
        nb = (sc == 3'b000) ? 5 : (sc == 3'b001) ? 6 : (sc == 3'b010) ? 7 :
             (sc == 3'b111) ? 9 : 8;
        fr = '1;
        fr[0] = 1'b0; rq[0] = "R3";
        p = 1'b0;
        for (int i = 0; i < nb; i++) begin
            fr[1+i] = d[i]; rq[1+i] = "R4"; p ^= d[i];
        end
        pos = 1 + nb;
        if (pm[1]) begin
            fr[pos] = p ^ pm[0]; rq[pos] = "R6"; pos++;
        end
        rq[pos] = "R7"; pos++;
        if (ts) begin rq[pos] = "R7"; pos++; end
        total = pos;

        @(negedge clk); #1;
        chk("R2", ready, 1'b1, id);
        data = d; size_code = sc; par_mode = pm; two_stop = ts; load = 1'b1;
        k = 0;
        while (k < total*16) begin
            @(negedge clk); #2;
            load = 1'b0;
            chk("R2", ready, 1'b0, id);
            chk(rq[k/16], txd, fr[k/16], id);
            if (tick) begin
                k++;
                if (k == 40) begin   // busy load with changed fields: R9, R10
                    load = 1'b1; data = ~d; size_code = ~sc;
                    par_mode = ~pm; two_stop = ~ts;
                end
            end
        end
        @(negedge clk); #2;
        load = 1'b0;
        chk("R2", ready, 1'b1, id);
        chk("R1", txd, 1'b1, id);
        // R10: no extra frame appears after the busy strobe
        for (int j = 0; j < 20; j++) begin
            @(negedge clk); #2;
            if (j == 19) chk("R10", txd, 1'b1, id);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", txd, 1'b1, -1);
        chk("R1", ready, 1'b1, -1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", txd, 1'b1, -2);
        chk("R1", ready, 1'b1, -2);
        // R4 R5 R7 R8: every size, parity and stop code
        for (int sc = 0; sc < 8; sc++)
            for (int pm = 0; pm < 4; pm++)
                for (int ts = 0; ts < 2; ts++) begin
                    logic [8:0] d;
                    d = 9'h155 ^ 9'((sc*64 + pm*8 + ts*3) * 29);
                    send(d, 3'(sc), 2'(pm), ts[0], sc*8 + pm*2 + ts);
                    send(~d, 3'(sc), 2'(pm), ts[0], 100 + sc*8 + pm*2 + ts);
                end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule